// File: doc/BRIEF.md
# Virtual Bank ID Matcher

This block lives on a memory controller card that carries several DRAM banks. Each bank answers to a bank number that software assigns. A single CSR holds one slot per bank. Each slot has a 4-bit virtual ID and an enable bit. At power-up, software loads the CSR by writing the whole word. The CSR is reached through the card's physical slot address, and that decode happens outside this block.

Every address-bus cycle carries a 4-bit bank number. When the valid strobe is high, all enabled slots compare their IDs against that number in parallel. The block then drives a registered one-hot select for the bank that matches. No address bits are decoded for bank choice. If two or more enabled slots hold the same ID, the slot with the lowest index takes the select and a duplicate flag is raised for that cycle. Software can read the CSR back. Slots that are not built, and spare bits inside built slots, read as zero.

Top module: `vid_bank_matcher`

## Requirements
- R1: After a cycle with `rst` high, every enable is clear, and `bank_sel` and `dup_err` are zero. A CSR read returns all zeros.
- R2: A cycle with `csr_wr` high loads every implemented slot i (i < NUM_BANKS) from the write word. The ID comes from bits 8i+3..8i and the enable from bit 8i+4.
- R3: The cycle after `csr_rd` is high, `csr_rdata` shows the stored ID in bits 8i+3..8i and the enable in bit 8i+4 for each implemented slot. All other bits are zero, including bits 8i+7..8i+5 and every bit of unimplemented slots.
- R4: The cycle after a cycle with `ab_valid` high, `bank_sel[i]` is high when slot i is enabled and its ID equals `ab_bank`.
- R5: A slot whose enable is clear never drives its select, whatever ID it holds.
- R6: The cycle after a cycle with `ab_valid` low, `bank_sel` is zero and `dup_err` is low.
- R7: When two or more enabled slots match, only the lowest-index matching slot is selected. In the same cycle, `dup_err` is high.
- R8: A CSR write in the same cycle as a valid compare does not affect that compare, which uses the old slot contents. The new contents apply from the next cycle.
- R9: `bank_sel` never has more than one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_wr | input | 1 | Write strobe for the virtual ID CSR |
| csr_rd | input | 1 | Read strobe; data appears next cycle |
| csr_wdata | input | 64 | Write word, 8 bits per slot |
| csr_rdata | output | 64 | Registered read word |
| ab_valid | input | 1 | Address-bus cycle valid |
| ab_bank | input | ID_W | Bank number carried by the bus cycle |
| bank_sel | output | NUM_BANKS | Registered one-hot bank select |
| dup_err | output | 1 | Registered flag: more than one enabled slot matched |

## Verification
The hardest cases to reach are the duplicate-ID case and a CSR write that collides with a bus compare. Both need software to load a deliberately inconsistent or changing table before the bus cycle arrives. The stimulus loads tables with repeated IDs and with mixed enables, then sweeps all sixteen bank numbers against each table. It then issues a write and a valid compare in the same cycle, followed by a second compare. This shows that the first compare used the old table and the second used the new one. The write words also put ones into spare bits and unimplemented slots, so the read-back masking is exercised.

// File: rtl/vid_pkg.sv
package vid_pkg;
  localparam int VID_MAX_SLOTS = 8;
  localparam int VID_SLOT_W    = 8;
  localparam int VID_EN_BIT    = 4;
  localparam int VID_CSR_W     = VID_MAX_SLOTS * VID_SLOT_W;
  localparam int VID_ID_W      = 4;
endpackage

// File: rtl/vid_slot_store.sv
module vid_slot_store #(
  parameter int NUM_BANKS = 4,
  parameter int ID_W      = vid_pkg::VID_ID_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr,
  input  logic [vid_pkg::VID_CSR_W-1:0]     wdata,
  output logic [NUM_BANKS*ID_W-1:0]         ids,
  output logic [NUM_BANKS-1:0]              ens,
  output logic [vid_pkg::VID_CSR_W-1:0]     view
);
  import vid_pkg::*;

  logic [ID_W-1:0]      id_q [NUM_BANKS];
  logic [NUM_BANKS-1:0] en_q;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        id_q[i] <= '0;
        en_q[i] <= 1'b0;
      end else if (wr) begin
        id_q[i] <= wdata[i*VID_SLOT_W +: ID_W];
        en_q[i] <= wdata[i*VID_SLOT_W + VID_EN_BIT];
      end
    end
    assign ids[i*ID_W +: ID_W] = id_q[i];
    assign ens[i]              = en_q[i];
  end

  for (genvar s = 0; s < VID_MAX_SLOTS; s++) begin : g_view
    if (s < NUM_BANKS) begin : g_impl
      always_comb begin
        view[s*VID_SLOT_W +: VID_SLOT_W]     = '0;
        view[s*VID_SLOT_W +: ID_W]           = id_q[s];
        view[s*VID_SLOT_W + VID_EN_BIT]      = en_q[s];
      end
    end else begin : g_absent
      assign view[s*VID_SLOT_W +: VID_SLOT_W] = '0;
    end
  end

  // R1: reset leaves every enable clear
  a_r1_reset_clears: assert property (@(posedge clk) rst |=> (en_q == '0));
  // R2: slot 0 enable follows the write word
  a_r2_write_loads: assert property (@(posedge clk) disable iff (rst)
    wr |=> (en_q[0] == $past(wdata[VID_EN_BIT])));
endmodule

// File: rtl/vid_match.sv
module vid_match #(
  parameter int NUM_BANKS = 4,
  parameter int ID_W      = vid_pkg::VID_ID_W
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      valid,
  input  logic [ID_W-1:0]           bank,
  input  logic [NUM_BANKS*ID_W-1:0] ids,
  input  logic [NUM_BANKS-1:0]      ens,
  output logic [NUM_BANKS-1:0]      sel,
  output logic                      dup
);
  logic [NUM_BANKS-1:0] hit;
  logic [NUM_BANKS-1:0] first;
  logic                 multi;

  for (genvar i = 0; i < NUM_BANKS; i++) begin : g_cmp
    assign hit[i] = ens[i] && (ids[i*ID_W +: ID_W] == bank);
  end

  assign first = hit & (~hit + NUM_BANKS'(1));
  assign multi = (hit & (hit - NUM_BANKS'(1))) != '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel <= '0;
      dup <= 1'b0;
    end else begin
      sel <= valid ? first : '0;
      dup <= valid && multi;
    end
  end

  // R9: select is at most one-hot
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(sel));
  // R6: idle bus gives no select next cycle
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (sel == '0 && !dup));
  // R7: a duplicate always comes with a winning select
  a_r7_dup_has_winner: assert property (@(posedge clk) disable iff (rst)
    dup |-> $onehot(sel));
  // R5: disabled slots cannot be selected
  a_r5_disabled_silent: assert property (@(posedge clk) disable iff (rst)
    valid |=> ((sel & ~$past(ens)) == '0));
endmodule

// File: rtl/vid_bank_matcher.sv
module vid_bank_matcher #(
  parameter int NUM_BANKS = 4,
  parameter int ID_W      = vid_pkg::VID_ID_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          csr_wr,
  input  logic                          csr_rd,
  input  logic [vid_pkg::VID_CSR_W-1:0] csr_wdata,
  output logic [vid_pkg::VID_CSR_W-1:0] csr_rdata,
  input  logic                          ab_valid,
  input  logic [ID_W-1:0]               ab_bank,
  output logic [NUM_BANKS-1:0]          bank_sel,
  output logic                          dup_err
);
  import vid_pkg::*;

  logic [NUM_BANKS*ID_W-1:0] ids;
  logic [NUM_BANKS-1:0]      ens;
  logic [VID_CSR_W-1:0]      view;

  vid_slot_store #(.NUM_BANKS(NUM_BANKS), .ID_W(ID_W)) u_store (
    .clk(clk), .rst(rst), .wr(csr_wr), .wdata(csr_wdata),
    .ids(ids), .ens(ens), .view(view)
  );

  vid_match #(.NUM_BANKS(NUM_BANKS), .ID_W(ID_W)) u_match (
    .clk(clk), .rst(rst), .valid(ab_valid), .bank(ab_bank),
    .ids(ids), .ens(ens), .sel(bank_sel), .dup(dup_err)
  );

  always_ff @(posedge clk) begin
    if (rst)         csr_rdata <= '0;
    else if (csr_rd) csr_rdata <= view;
  end

  // R3: spare bits of slot 0 always read as zero
  a_r3_spare_zero: assert property (@(posedge clk) disable iff (rst)
    csr_rdata[VID_SLOT_W-1:VID_EN_BIT+1] == '0);
endmodule

// File: tb/vid_bank_matcher_test.sv
module vid_bank_matcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int NF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_wr = 1'b0, csr_rd = 1'b0;
  logic [63:0] csr_wdata = '0;
  logic [63:0] csr_rdata;
  logic        ab_valid = 1'b0;
  logic [3:0]  ab_bank = '0;
  logic [NF-1:0] bank_sel;
  logic        dup_err;

  int checks = 0;
  int fails  = 0;
  logic [3:0] m_id [NF];
  logic       m_en [NF];

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_bank_matcher #(.NUM_BANKS(NF), .ID_W(4)) uut (
    .clk(clk), .rst(rst), .csr_wr(csr_wr), .csr_rd(csr_rd),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
    .ab_valid(ab_valid), .ab_bank(ab_bank),
    .bank_sel(bank_sel), .dup_err(dup_err)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] write_word();
    logic [63:0] w = {64{1'b1}};
    for (int i = 0; i < NF; i++) begin
      w[i*8 +: 8] = {3'b111, m_en[i], m_id[i]};
    end
    return w;
  endfunction

  function automatic logic [63:0] read_view();
    logic [63:0] v = '0;
    for (int i = 0; i < NF; i++) begin
      v[i*8 +: 5] = {m_en[i], m_id[i]};
    end
    return v;
  endfunction

  task automatic set_table(input logic [15:0] ids, input logic [3:0] ens);
    for (int i = 0; i < NF; i++) begin
      m_id[i] = ids[i*4 +: 4];
      m_en[i] = ens[i];
    end
  endtask

  task automatic program_table();
    csr_wr = 1'b1; csr_wdata = write_word();
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic read_check(input string req);
    csr_rd = 1'b1;
    @(negedge clk);
    csr_rd = 1'b0;
    check(req, csr_rdata, read_view());
  endtask

  task automatic expect_for(input logic [3:0] b, output logic [NF-1:0] s, output logic d);
    int cnt = 0;
    s = '0;
    for (int i = 0; i < NF; i++) begin
      if (m_en[i] && m_id[i] == b) begin
        if (cnt == 0) s[i] = 1'b1;
        cnt++;
      end
    end
    d = (cnt > 1);
  endtask

  task automatic sweep(input string req);
    logic [NF-1:0] es;
    logic ed;
    for (int b = 0; b < 16; b++) begin
      ab_valid = 1'b1; ab_bank = 4'(b);
      expect_for(4'(b), es, ed);
      @(negedge clk);
      ab_valid = 1'b0;
      check({req, " sel"}, 64'(bank_sel), 64'(es));
      check({req, " dup"}, 64'(dup_err), 64'(ed));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NF-1:0] es;
    logic ed;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 sel", 64'(bank_sel), 64'd0);
    check("R1 dup", 64'(dup_err), 64'd0);
    set_table(16'h0, 4'h0);
    read_check("R1 read");
    sweep("R1 no match after reset");

    // R2 R3 R4: distinct IDs, all enabled
    set_table({4'd0, 4'd12, 4'd7, 4'd3}, 4'hF);
    program_table();
    read_check("R2 R3 readback");
    sweep("R4 distinct");

    // R6: idle bus with a matching number
    ab_valid = 1'b0; ab_bank = 4'd7;
    @(negedge clk);
    check("R6 idle sel", 64'(bank_sel), 64'd0);
    check("R6 idle dup", 64'(dup_err), 64'd0);

    // R7 R5: duplicates with one disabled
    set_table({4'd5, 4'd9, 4'd5, 4'd5}, 4'b1101);
    program_table();
    read_check("R3 mixed readback");
    sweep("R7 dup mixed");

    // R5: all disabled
    set_table({4'd2, 4'd2, 4'd1, 4'd0}, 4'h0);
    program_table();
    sweep("R5 disabled");

    // R7 R9: all same ID
    set_table({4'd15, 4'd15, 4'd15, 4'd15}, 4'hF);
    program_table();
    sweep("R7 R9 all same");

    // R8: write colliding with compare
    set_table({4'd4, 4'd3, 4'd2, 4'd1}, 4'hF);
    program_table();
    set_table({4'd8, 4'd6, 4'd2, 4'd1}, 4'b1110);
    csr_wr = 1'b1; csr_wdata = write_word();
    ab_valid = 1'b1; ab_bank = 4'd3;
    @(negedge clk);
    csr_wr = 1'b0; ab_valid = 1'b0;
    check("R8 old table", 64'(bank_sel), 64'b0100);
    ab_valid = 1'b1; ab_bank = 4'd3;
    @(negedge clk);
    ab_valid = 1'b0;
    check("R8 new table miss", 64'(bank_sel), 64'd0);
    ab_valid = 1'b1; ab_bank = 4'd1;
    expect_for(4'd1, es, ed);
    @(negedge clk);
    ab_valid = 1'b0;
    check("R8 R5 new table disabled", 64'(bank_sel), 64'(es));
    sweep("R8 new table");

    // R1: reset again clears enables
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    set_table(16'h0, 4'h0);
    read_check("R1 reread");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule